// File: doc/BRIEF.md
# Region Write-Protected RAM

A byte-wide, single-port synchronous RAM whose address space is cut into equal regions, each guarded by one bit of a protection mask. A data write reaches the array only if the addressed region's mask bit is 1; otherwise it is dropped, the stored bytes stay as they were, and a sticky violation flag is raised. Reads are never blocked.

The mask has its own write and read strobes. It accepts a new value only while the privilege input is high. That input is normally tied to the processor's interrupt-enable bit, so only interrupt handlers or privileged start-up code can move the protection boundaries. An accepted mask write also clears the violation flag. The mask is reached as bytes: the byte lane is taken from the two low address bits. A build parameter removes protection, and then every data write lands.

Top module: `wp_ram`

## Requirements
- R1: With the default geometry (10 address bits, 16 regions of 64 bytes), the region index is `addr[9:6]`. In general it is the top `REGION_W` address bits.
- R2: A data write (`mem_we`) is stored only when the mask bit of the addressed region is 1. Otherwise the array keeps its old contents.
- R3: A mask write (`mask_we`) takes effect only while `priv` is 1. With `priv` at 0 the mask is unchanged.
- R4: With `PROTECT` = 0, every data write is stored whatever the mask holds, and `violation` stays 0.
- R5: Reads are never blocked. `rd_data` shows the byte at `addr` one clock after the address is presented with `mask_re` low.
- R6: After reset every mask bit is 1 and `violation` is 0.
- R7: With `mask_re` high, `rd_data` shows mask byte lane `addr[1:0]` one clock later. Bit i of lane k is the mask bit of region 8k+i. Lanes above the last mask byte read as 0x00.
- R8: A blocked data write sets `violation` on the next clock. It stays set until a mask write is accepted, which clears it.
- R9: An accepted mask write replaces only the byte lane chosen by `addr[1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Byte address; the low two bits pick the mask lane for mask accesses |
| wr_data | input | 8 | Write data for the array or the mask |
| mem_we | input | 1 | Data write strobe |
| mask_we | input | 1 | Mask write strobe |
| mask_re | input | 1 | Selects mask readback instead of array data |
| priv | input | 1 | Privilege flag that enables mask writes |
| rd_data | output | 8 | Registered read data |
| violation | output | 1 | Sticky flag for a blocked data write |

## Verification
The hardest situation to produce is a violation flag that survives an unprivileged mask write and then clears on a privileged one. Reaching it takes four steps in order: lock a region, aim a write at it, try to change the mask with `priv` low, then try again with it high. The stimulus table walks that exact sequence and reads the mask back between the steps. It also writes the last byte of one region next to a locked neighbour, which tests the region boundary. A second instance built with protection off receives the same traffic, so the difference between the two shows the effect of the gate.

// File: rtl/wp_ram_pkg.sv
// Shared constants for the region write-protected RAM.
// Assumes the mask is handled in 8-bit lanes and that at most four lanes exist.
package wp_ram_pkg;
    localparam int BYTE_W = 8;
    localparam int LANE_W = 2;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/wp_mask_reg.sv
// Per-region protection mask, written and read as byte lanes.
// Assumes NUM_REGIONS is a multiple of 8 and at most 32.
// A write is taken only while priv is high; the reset value is all ones.
module wp_mask_reg
    import wp_ram_pkg::*;
#(
    parameter int NUM_REGIONS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic                   priv,
    input  logic [LANE_W-1:0]      lane,
    input  byte_t                  wdata,
    output logic [NUM_REGIONS-1:0] mask,
    output byte_t                  rd_byte,
    output logic                   accepted
);
    localparam int NUM_LANES = (NUM_REGIONS + BYTE_W - 1) / BYTE_W;
    localparam int PAD_W     = NUM_LANES * BYTE_W;

    logic [PAD_W-1:0] mask_q;

    // A mask write counts only with privilege.
    assign accepted = we && priv;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        // Each lane loads its byte when it is the addressed lane.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[g*BYTE_W +: BYTE_W] <= '1;
            else if (accepted && lane == LANE_W'(g))
                mask_q[g*BYTE_W +: BYTE_W] <= wdata;
        end
    end

    // Lane readback; lanes past the mask read as zero.
    always_comb begin
        rd_byte = '0;
        for (int k = 0; k < NUM_LANES; k++)
            if (lane == LANE_W'(k))
                rd_byte = mask_q[k*BYTE_W +: BYTE_W];
    end

    assign mask = mask_q[NUM_REGIONS-1:0];
endmodule

// File: rtl/wp_write_gate.sv
// Decides whether a data write may reach the array and keeps the sticky violation flag.
// Assumes the region index is the top REGION_W address bits.
// With PROTECT = 0 every write passes and the flag stays low.
module wp_write_gate #(
    parameter int ADDR_W   = 10,
    parameter int REGION_W = 4,
    parameter bit PROTECT  = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     mem_we,
    input  logic [(1<<REGION_W)-1:0] mask,
    input  logic                     mask_accepted,
    output logic                     wr_en,
    output logic                     violation
);
    logic [REGION_W-1:0] region;
    logic                allowed;

    assign region  = addr[ADDR_W-1 -: REGION_W];
    assign allowed = !PROTECT || mask[region];
    assign wr_en   = mem_we && allowed;

    if (PROTECT) begin : g_flag
        logic flag_q;
        // A blocked write sets the flag; an accepted mask write clears it; setting wins.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q <= 1'b0;
            else if (mem_we && !allowed)
                flag_q <= 1'b1;
            else if (mask_accepted)
                flag_q <= 1'b0;
        end
        assign violation = flag_q;
    end else begin : g_noflag
        assign violation = 1'b0;
    end
endmodule

// File: rtl/wp_ram_array.sv
// Byte storage with a registered read port and read-before-write behaviour.
// Assumes the array is not reset; its contents are undefined until written.
module wp_ram_array
    import wp_ram_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             wdata,
    output byte_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    byte_t mem [DEPTH];

    // Write when gated in; the read register always follows the address.
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/wp_ram.sv
// Top level of the region write-protected RAM.
// Assumes the caller keeps mem_we and mask_we one-hot per cycle.
// Read data is one cycle late; the mask_re registered with the address picks mask or array data.
module wp_ram
    import wp_ram_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int REGION_W = 4,
    parameter bit PROTECT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    input  logic              mem_we,
    input  logic              mask_we,
    input  logic              mask_re,
    input  logic              priv,
    output logic [7:0]        rd_data,
    output logic              violation
);
    localparam int NUM_REGIONS = 1 << REGION_W;

    logic [NUM_REGIONS-1:0] mask_bits;
    byte_t                  mask_byte;
    byte_t                  mask_byte_q;
    byte_t                  mem_rdata;
    logic                   mask_ok;
    logic                   mem_wr_en;
    logic                   sel_mask_q;

    wp_mask_reg #(.NUM_REGIONS(NUM_REGIONS)) u_mask (
        .clk(clk), .rst_n(rst_n), .we(mask_we), .priv(priv),
        .lane(addr[LANE_W-1:0]), .wdata(wr_data),
        .mask(mask_bits), .rd_byte(mask_byte), .accepted(mask_ok)
    );

    wp_write_gate #(.ADDR_W(ADDR_W), .REGION_W(REGION_W), .PROTECT(PROTECT)) u_gate (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mem_we(mem_we),
        .mask(mask_bits), .mask_accepted(mask_ok),
        .wr_en(mem_wr_en), .violation(violation)
    );

    wp_ram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .we(mem_wr_en), .addr(addr),
        .wdata(wr_data), .rdata(mem_rdata)
    );

    // Register the readback source and the mask byte in step with the array read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_mask_q  <= 1'b0;
            mask_byte_q <= '0;
        end else begin
            sel_mask_q  <= mask_re;
            mask_byte_q <= mask_byte;
        end
    end

    assign rd_data = sel_mask_q ? mask_byte_q : mem_rdata;
endmodule

// File: rtl/wp_ram_chk.sv
// Property checker for wp_ram, attached through bind.
module wp_ram_chk #(
    parameter int ADDR_W   = 10,
    parameter int REGION_W = 4,
    parameter bit PROTECT  = 1'b1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        addr,
    input logic                     mem_we,
    input logic                     mask_we,
    input logic                     priv,
    input logic [(1<<REGION_W)-1:0] mask,
    input logic                     violation
);
    logic [REGION_W-1:0] region;
    logic                blocked;
    assign region  = addr[ADDR_W-1 -: REGION_W];
    assign blocked = PROTECT && mem_we && !mask[region];

    a_r8_blocked_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> violation);
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (violation && !(mask_we && priv)) |=> violation);
    a_r8_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && priv && !blocked) |=> !violation);
    a_r8_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!violation && !blocked) |=> !violation);
    a_r3_mask_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !(mask_we && priv) |=> $stable(mask));
    a_r6_reset_open: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&mask && !violation));
    a_r4_open_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!PROTECT && mem_we) |=> !violation);
endmodule

bind wp_ram wp_ram_chk #(.ADDR_W(ADDR_W), .REGION_W(REGION_W), .PROTECT(PROTECT)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mem_we(mem_we), .mask_we(mask_we),
    .priv(priv), .mask(mask_bits), .violation(violation)
);

// File: tb/wp_ram_bench.sv
// Bench for wp_ram: a vector table walked by one loop, then directed checks.
module wp_ram_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] addr = '0;
    logic [7:0] wr_data = '0;
    logic       mem_we = 1'b0, mask_we = 1'b0, mask_re = 1'b0, priv = 1'b0;
    logic [7:0] rd_data, rd_data_o;
    logic       violation, violation_o;
    int checks = 0, errors = 0;

    always #10ns clk = ~clk;

    wp_ram #(.ADDR_W(10), .REGION_W(4), .PROTECT(1'b1)) u_wp_ram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .mem_we(mem_we),
        .mask_we(mask_we), .mask_re(mask_re), .priv(priv),
        .rd_data(rd_data), .violation(violation));

    wp_ram #(.ADDR_W(10), .REGION_W(4), .PROTECT(1'b0)) u_wp_ram_open (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .mem_we(mem_we),
        .mask_we(mask_we), .mask_re(mask_re), .priv(priv),
        .rd_data(rd_data_o), .violation(violation_o));

    // {op, requirement, addr, data, priv}. op: 1 data write, 2 data read expect,
    // 3 mask write, 4 mask read expect, 5 violation expect (data bit 0)
    localparam int N = 27;
    localparam logic [31:0] TABLE [N] = '{
        {4'd1, 4'd2, 12'h000, 8'hA5, 4'd0},
        {4'd2, 4'd5, 12'h000, 8'hA5, 4'd0},  // R5
        {4'd1, 4'd2, 12'h3FF, 8'h5A, 4'd0},
        {4'd2, 4'd2, 12'h3FF, 8'h5A, 4'd0},  // R2
        {4'd3, 4'd9, 12'h000, 8'hFE, 4'd1},
        {4'd4, 4'd9, 12'h000, 8'hFE, 4'd0},  // R9
        {4'd4, 4'd9, 12'h001, 8'hFF, 4'd0},  // R9 other lane untouched
        {4'd1, 4'd2, 12'h000, 8'h11, 4'd0},
        {4'd5, 4'd8, 12'h000, 8'h01, 4'd0},  // R8
        {4'd2, 4'd2, 12'h000, 8'hA5, 4'd0},  // R2 blocked
        {4'd1, 4'd1, 12'h040, 8'h22, 4'd0},
        {4'd2, 4'd1, 12'h040, 8'h22, 4'd0},  // R1 region 1
        {4'd3, 4'd3, 12'h001, 8'h7F, 4'd0},
        {4'd4, 4'd3, 12'h001, 8'hFF, 4'd0},  // R3
        {4'd5, 4'd8, 12'h000, 8'h01, 4'd0},  // R8 sticky
        {4'd3, 4'd3, 12'h001, 8'h7F, 4'd1},
        {4'd5, 4'd8, 12'h000, 8'h00, 4'd0},  // R8 clear
        {4'd4, 4'd7, 12'h001, 8'h7F, 4'd0},  // R7
        {4'd1, 4'd2, 12'h3FF, 8'h77, 4'd0},
        {4'd2, 4'd2, 12'h3FF, 8'h5A, 4'd0},
        {4'd5, 4'd8, 12'h000, 8'h01, 4'd0},
        {4'd1, 4'd1, 12'h3BF, 8'h33, 4'd0},
        {4'd2, 4'd1, 12'h3BF, 8'h33, 4'd0},  // R1 boundary 14/15
        {4'd4, 4'd7, 12'h002, 8'h00, 4'd0},  // R7 lane past mask
        {4'd3, 4'd9, 12'h000, 8'hFF, 4'd1},
        {4'd1, 4'd2, 12'h000, 8'h11, 4'd0},
        {4'd2, 4'd2, 12'h000, 8'h11, 4'd0}
    };

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] v);
        logic [3:0] op  = v[31:28];
        int         req = int'(v[27:24]);
        logic [7:0] d   = v[11:4];
        @(negedge clk);
        if (op == 4'd5) begin
            check(req, {7'b0, violation}, d);
        end else begin
            addr    = v[21:12];
            wr_data = d;
            priv    = v[0];
            mem_we  = (op == 4'd1);
            mask_we = (op == 4'd3);
            mask_re = (op == 4'd4);
            @(negedge clk);
            if (op == 4'd2 || op == 4'd4) check(req, rd_data, d);
            mem_we = 0; mask_we = 0; mask_re = 0; priv = 0;
        end
    endtask

    initial begin
        #2ms;
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6 reset state
        check(6, {7'b0, violation}, 8'h00);
        apply({4'd4, 4'd6, 12'h000, 8'hFF, 4'd0});
        apply({4'd4, 4'd6, 12'h001, 8'hFF, 4'd0});
        for (int i = 0; i < N; i++) apply(TABLE[i]);
        // R4: lock region 0 and write there; only the open instance stores it
        apply({4'd3, 4'd4, 12'h000, 8'h00, 4'd1});
        apply({4'd1, 4'd4, 12'h000, 8'hC3, 4'd0});
        @(negedge clk);
        check(4, {7'b0, violation_o}, 8'h00);
        check(8, {7'b0, violation}, 8'h01);
        addr = 10'h000;
        @(negedge clk);
        check(4, rd_data_o, 8'hC3);
        check(2, rd_data, 8'h11);
        // R6: a second reset restores the open mask and clears the flag
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(6, {7'b0, violation}, 8'h00);
        apply({4'd4, 4'd6, 12'h000, 8'hFF, 4'd0});
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule